// File: doc/BRIEF.md
# Receiver Polling Duty-Cycle Sequencer

This block keeps a radio receiver asleep most of the time and wakes it only long enough to decide whether a transmitter is present. A phase state machine moves through four phases: a long idle phase, a warm-up phase, a qualification phase and a listening phase. In the idle phase the signal-processing chain is switched off. When the programmed idle time runs out, the chain is switched on for a fixed warm-up time. The demodulated data line is then checked edge by edge against a bit-period window.

If enough consecutive edge-to-edge intervals fall inside the window, the block enters the listening phase. It passes the data stream through and stays there until a one-cycle off command arrives. A failed qualification, or an off command in any awake phase, sends it straight back to idle and restarts the idle timer. Each clock cycle of `clk` counts as one basic clock period.

Top module: `rx_poll_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the block in the idle phase with all counters cleared. While reset is held and right after it, `proc_en`, `rx_active` and `data_out` are 0. The first idle phase after reset lasts the full programmed time.
- R2: The idle phase lasts `sleep_word` × F × `SLEEP_UNIT` cycles, where F is the extension factor. A product of 0 is treated as one cycle.
- R3: Extension codes 0, 1, 2 and 3 on `ext_code` give F = 1, 2, 4 and 8.
- R4: Extension codes 4 to 7 give F = 1.
- R5: The warm-up phase lasts (4 − `baud_sel`) × `STARTUP_UNIT` cycles. Qualification follows it. `proc_en` is 1 in the warm-up, qualification and listening phases.
- R6: The nominal bit period is P = `BIT_BASE` << (3 − `baud_sel`). An interval is valid when it lies between P − P/4 and P + P/4 cycles, both limits included. An interval is the number of cycles between two cycles in which `data_in` differs from its value one cycle earlier. The first edge in qualification only starts the measurement.
- R7: After `CHECK_BITS` consecutive valid intervals, `rx_active` rises in the cycle after the edge that closes the last one.
- R8: An interval shorter than the lower limit fails the check at that edge. The block is idle from the next cycle.
- R9: When the running interval count (from phase entry or from the last edge) exceeds the upper limit, the check fails and the block goes idle. With no edge at all, qualification lasts upper limit + 2 cycles.
- R10: While `rx_active` is 1, `data_out` follows `data_in` in the same cycle, and the block stays in the listening phase until an off command. Otherwise `data_out` is 0.
- R11: `off_cmd` high in any awake phase makes the block idle in the next cycle. The idle timer restarts, so a full idle period follows.
- R12: `off_cmd` during the idle phase has no effect on its length or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_word | input | 5 | Idle-time multiplier |
| ext_code | input | 3 | Idle-time extension code |
| baud_sel | input | 2 | Bit-rate range, 0 slowest, 3 fastest |
| data_in | input | 1 | Demodulated data |
| off_cmd | input | 1 | One-cycle return-to-idle command |
| proc_en | output | 1 | Signal-processing chain enable |
| rx_active | output | 1 | Listening phase flag |
| data_out | output | 1 | Data pass-through, gated by `rx_active` |

## Verification
A wrong phase or a wrong counter shows up only as a changed length of a `proc_en` or `rx_active` level, so the bench measures every such segment in cycles. An idle-timer error becomes visible at the next wake-up. A warm-up or window error shifts the end of the awake segment by at least one cycle within the same poll. A pass-through or off-command fault shows up on `data_out` or `proc_en` within one cycle.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;

  typedef enum logic [1:0] {PH_SLEEP, PH_START, PH_CHECK, PH_RECV} phase_t;

  function automatic int unsigned ext_factor(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned sleep_cycles(input logic [4:0] word,
                                               input logic [2:0] code,
                                               input int unsigned unit);
    int unsigned n;
    n = 32'(word) * ext_factor(code) * unit;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned startup_cycles(input logic [1:0] baud,
                                                 input int unsigned unit);
    return (4 - 32'(baud)) * unit;
  endfunction

  function automatic int unsigned bit_period(input logic [1:0] baud,
                                             input int unsigned base);
    return base << (3 - 32'(baud));
  endfunction

  function automatic int unsigned win_lo(input int unsigned p);
    return p - p / 4;
  endfunction

  function automatic int unsigned win_hi(input int unsigned p);
    return p + p / 4;
  endfunction

endpackage

// File: rtl/rx_poll_timer.sv
module rx_poll_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] len,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = (cnt == len - W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (!done)     cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/rx_poll_bitchk.sv
module rx_poll_bitchk #(
  parameter int ICW        = 8,
  parameter int CHECK_BITS = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           active,
  input  logic           data_in,
  input  logic [ICW-1:0] lo,
  input  logic [ICW-1:0] hi,
  output logic           edge_seen,
  output logic           pass,
  output logic           fail
);
  localparam int VW = $clog2(CHECK_BITS + 1);

  logic           d_q;
  logic           armed;
  logic [ICW-1:0] ic;
  logic [VW-1:0]  vcnt;
  logic           in_win;

  assign edge_seen = data_in ^ d_q;
  assign in_win    = (ic >= lo) && (ic <= hi);
  assign fail = active && ((edge_seen && armed && !in_win) || (!edge_seen && ic > hi));
  assign pass = active && edge_seen && armed && in_win && (vcnt == VW'(CHECK_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) d_q <= 1'b0;
    else     d_q <= data_in;
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      ic    <= '0;
      armed <= 1'b0;
      vcnt  <= '0;
    end else if (active) begin
      if (edge_seen) begin
        ic    <= ICW'(1);
        armed <= 1'b1;
        if (armed && in_win) vcnt <= vcnt + VW'(1);
      end else if (ic != '1) begin
        ic <= ic + ICW'(1);
      end
    end
  end
endmodule

// File: rtl/rx_poll_seq.sv
module rx_poll_seq
  import rx_poll_pkg::*;
#(
  parameter int unsigned SLEEP_UNIT   = 1024,
  parameter int unsigned STARTUP_UNIT = 16,
  parameter int unsigned BIT_BASE     = 16,
  parameter int unsigned CHECK_BITS   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] sleep_word,
  input  logic [2:0] ext_code,
  input  logic [1:0] baud_sel,
  input  logic       data_in,
  input  logic       off_cmd,
  output logic       proc_en,
  output logic       rx_active,
  output logic       data_out
);
  localparam int unsigned MAX_SLP = 31 * 8 * SLEEP_UNIT;
  localparam int unsigned MAX_ST  = 4 * STARTUP_UNIT;
  localparam int unsigned MAX_T   = (MAX_SLP > MAX_ST) ? MAX_SLP : MAX_ST;
  localparam int          TW      = $clog2(MAX_T + 1);
  localparam int unsigned MAX_HI  = win_hi(BIT_BASE << 3);
  localparam int          ICW     = $clog2(MAX_HI + 2) + 1;

  phase_t         st_q, st_d;
  logic [TW-1:0]  tmr_len;
  logic           tmr_done;
  logic           phase_restart;
  logic           bc_start, bc_active, bc_edge, bc_pass, bc_fail;
  logic [ICW-1:0] bc_lo, bc_hi;

  assign tmr_len = (st_q == PH_SLEEP) ? TW'(sleep_cycles(sleep_word, ext_code, SLEEP_UNIT))
                                      : TW'(startup_cycles(baud_sel, STARTUP_UNIT));
  assign bc_lo = ICW'(win_lo(bit_period(baud_sel, BIT_BASE)));
  assign bc_hi = ICW'(win_hi(bit_period(baud_sel, BIT_BASE)));

  always_comb begin
    st_d = st_q;
    case (st_q)
      PH_SLEEP: if (tmr_done) st_d = PH_START;
      PH_START: begin
        if (off_cmd)       st_d = PH_SLEEP;
        else if (tmr_done) st_d = PH_CHECK;
      end
      PH_CHECK: begin
        if (off_cmd || bc_fail) st_d = PH_SLEEP;
        else if (bc_pass)       st_d = PH_RECV;
      end
      PH_RECV: if (off_cmd) st_d = PH_SLEEP;
      default: st_d = PH_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= PH_SLEEP;
    else     st_q <= st_d;
  end

  assign phase_restart = (st_d != st_q);
  assign bc_start      = phase_restart && (st_d == PH_CHECK);
  assign bc_active     = (st_q == PH_CHECK);

  rx_poll_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .restart(phase_restart), .len(tmr_len), .done(tmr_done)
  );

  rx_poll_bitchk #(.ICW(ICW), .CHECK_BITS(CHECK_BITS)) u_bc (
    .clk(clk), .rst(rst), .start(bc_start), .active(bc_active), .data_in(data_in),
    .lo(bc_lo), .hi(bc_hi), .edge_seen(bc_edge), .pass(bc_pass), .fail(bc_fail)
  );

  assign proc_en   = (st_q != PH_SLEEP);
  assign rx_active = (st_q == PH_RECV);
  assign data_out  = rx_active & data_in;
endmodule

// File: rtl/rx_poll_seq_chk.sv
module rx_poll_seq_chk (
  input logic clk,
  input logic rst,
  input logic proc_en,
  input logic rx_active,
  input logic off_cmd,
  input logic tmr_done,
  input logic bc_pass,
  input logic bc_fail
);
  // R11
  off_wakes_down_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_en && off_cmd) |=> !proc_en);

  // R12
  off_idle_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!proc_en && off_cmd && !tmr_done) |=> !proc_en);

  // R8
  fail_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    bc_fail |=> (!proc_en && !rx_active));

  // R7
  rx_after_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_active) |-> $past(bc_pass));

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_active && !off_cmd) |=> rx_active);

  // R6
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bc_pass && bc_fail));

  // R5
  wake_not_rx_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(proc_en) |-> !rx_active);
endmodule

bind rx_poll_seq rx_poll_seq_chk u_chk (
  .clk(clk), .rst(rst), .proc_en(proc_en), .rx_active(rx_active), .off_cmd(off_cmd),
  .tmr_done(tmr_done), .bc_pass(bc_pass), .bc_fail(bc_fail)
);

// File: tb/tb_rx_poll_seq.sv
module tb_rx_poll_seq;
  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] sleep_word;
  logic [2:0] ext_code;
  logic [1:0] baud_sel;
  logic data_in = 1'b0, off_cmd = 1'b0;
  logic proc_en, rx_active, data_out;

  int checks = 0, errors = 0;

  typedef struct { int code; int dur; string tag; } exp_t;
  exp_t q[$];

  rx_poll_seq #(.SLEEP_UNIT(4), .STARTUP_UNIT(4), .BIT_BASE(8), .CHECK_BITS(3)) dut (
    .clk(clk), .rst(rst), .sleep_word(sleep_word), .ext_code(ext_code), .baud_sel(baud_sel),
    .data_in(data_in), .off_cmd(off_cmd), .proc_en(proc_en), .rx_active(rx_active),
    .data_out(data_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input int code, input int dur, input string tag);
    exp_t e;
    e.code = code; e.dur = dur; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: segment lengths of the phase code {idle=0, awake=1, listen=2}
  int  mon_prev, mon_cnt, mon_cur;
  bit  in_rst = 1'b1;
  exp_t got;
  always @(negedge clk) begin
    if (rst) in_rst = 1'b1;
    else begin
      mon_cur = rx_active ? 2 : (proc_en ? 1 : 0);
      if (in_rst) begin
        in_rst = 1'b0; mon_prev = mon_cur; mon_cnt = 1;
      end else if (mon_cur != mon_prev) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected phase change actual %0d expected none", mon_cur);
        end else begin
          got = q.pop_front();
          chk(got.tag, mon_prev, got.code, "segment phase");
          chk(got.tag, mon_cnt, got.dur, "segment cycles");
        end
        mon_prev = mon_cur; mon_cnt = 1;
      end else mon_cnt++;
    end
  end

  task automatic wait_awake();
    do @(negedge clk); while (!proc_en);
  endtask
  task automatic wait_idle();
    do @(negedge clk); while (proc_en);
  endtask
  task automatic wait_rx();
    do @(negedge clk); while (!rx_active);
  endtask
  task automatic toggles(input int first, input int gap, input int n);
    repeat (first) @(negedge clk);
    #1 data_in = ~data_in;
    for (int i = 1; i < n; i++) begin
      repeat (gap) @(negedge clk);
      #1 data_in = ~data_in;
    end
  endtask
  task automatic pulse_off();
    #1 off_cmd = 1'b1;
    @(negedge clk);
    #1 off_cmd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R7 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    sleep_word = 5'd2; ext_code = 3'd1; baud_sel = 2'd3;
    push(0, 16, "R1");
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk); #1;
    chk("R1", proc_en, 0, "proc_en after reset");
    chk("R1", rx_active, 0, "rx_active after reset");
    chk("R1", data_out, 0, "data_out after reset");

    // no edges: 4 warm-up + 12 check cycles (R9)
    wait_awake();
    push(1, 16, "R9");
    sleep_word = 5'd1; ext_code = 3'd3; push(0, 32, "R3");
    wait_idle();

    // period 8 intervals: listen after 31 awake cycles (R7)
    wait_awake();
    push(1, 31, "R7"); push(2, 5, "R10");
    sleep_word = 5'd3; ext_code = 3'd5; push(0, 12, "R4");
    toggles(6, 8, 4);
    wait_rx();
    for (int i = 0; i < 4; i++) begin
      #1 data_in = ~data_in;
      #1 chk("R10", data_out, data_in, "pass-through");
      @(negedge clk);
    end
    pulse_off();
    data_in = 1'b1;
    #1 chk("R10", data_out, 0, "data_out idle");

    // interval 4 too short (R8)
    wait_awake();
    push(1, 11, "R8");
    sleep_word = 5'd0; push(0, 1, "R2");
    toggles(6, 4, 2);
    wait_idle();

    // interval 12 too long (R9)
    wait_awake();
    push(1, 18, "R9");
    sleep_word = 5'd2; ext_code = 3'd1; push(0, 16, "R2");
    toggles(6, 12, 2);
    wait_idle();

    // upper boundary 10 accepted, off in listen (R6, R11)
    wait_awake();
    push(1, 37, "R6"); push(2, 1, "R11"); push(0, 16, "R11");
    toggles(6, 10, 4);
    wait_rx();
    pulse_off();

    // lower boundary 6 accepted, off during idle ignored (R6, R12)
    wait_awake();
    push(1, 25, "R6"); push(2, 1, "R11"); push(0, 16, "R12");
    toggles(6, 6, 4);
    wait_rx();
    pulse_off();
    repeat (4) @(negedge clk);
    pulse_off();
    chk("R12", proc_en, 0, "proc_en after idle off");

    // off during warm-up (R11)
    wait_awake();
    push(1, 2, "R11"); push(0, 16, "R2");
    @(negedge clk);
    pulse_off();
    baud_sel = 2'd0;
    push(1, 98, "R5");

    // slowest range, no edges: 16 warm-up + 82 check (R5)
    wait_awake();
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R5", q.size(), 0, "pending segments");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule